// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers event pulses from a small processor's timers, serial ports, converters, one external pin and a four-pin change detector. It holds one sticky flag, one enable bit and one priority bit for each source. From these, and from a small control word, it produces a request to the core, a vector address and a record of which service level is running. Software reaches all state through one register port that shares its address for reads and writes.

There are two modes. In single-vector mode, the first global bit gates every source and the second bit also gates the sources marked as peripheral. Every request goes to address 0x0008, and no request is raised while a routine runs. In two-level mode, the first global bit enables the high-priority sources and the second enables the low-priority ones. High requests go to 0x0008 and low requests go to 0x0018. A high request may preempt a running low routine. Nothing interrupts a high routine. The core samples the request only at instruction boundaries, sends a one-cycle acknowledge when it vectors, and sends a one-cycle return when a routine ends.

Source numbering: bit 0 is the external pin, bit 1 is the pin-change detector, and bits 2 and up are the event pulses `evt_i[0]` and up. Register addresses: 0 holds the flags, 1 the enables, 2 the priorities (1 means high), and 3 the control word. The control word's bits are: bit 0 two-level mode, bit 1 global enable A, bit 2 global enable B, bit 3 external-pin edge select. `level_o` bit 1 means a high routine is active and bit 0 means a low routine is active.

Top module: `irq_ctrl2`

## Requirements
- R1: After reset, all four registers read 0, `irq_req_o` is 0 and `level_o` is 0.
- R2: An `evt_i` pulse sets its flag, and the flag reads back as set from the next cycle. A write of 0 to the flag register in the same cycle as the pulse still leaves that flag set.
- R3: The external-pin flag (bit 0) sets on a rising edge of `ext_pin_i` when control bit 3 is 1, and on a falling edge when it is 0. The other edge has no effect.
- R4: A change in state on any one of the four `pc_pins_i` sets flag bit 1.
- R5: A source can raise a request only when both its flag and its enable bit are set. `irq_req_o` is never high while `boundary_i` is low.
- R6: In single-vector mode (control bit 0 = 0), control bit 1 gates all sources and control bit 2 also gates the sources in `PERIPH_MASK`. The priority bits have no effect, and `vec_o` is 0x0008.
- R7: In two-level mode, control bit 1 enables the high-priority sources with vector 0x0008 and control bit 2 enables the low-priority sources with vector 0x0018. When both levels are pending, the high level wins.
- R8: An acknowledge given while a request is raised records the level served: high for vector 0x0008, low for vector 0x0018. In single-vector mode, no request is raised while a routine is active.
- R9: While a low routine is active, only a high request is raised. While a high routine is active, no request is raised.
- R10: A return pulse ends the innermost active level: high first, then low.
- R11: Acknowledging does not clear any flag. A flag left set raises a request again once the level that blocked it has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | NEV | One-cycle event pulses, flag bits 2 and up |
| ext_pin_i | input | 1 | External interrupt pin |
| pc_pins_i | input | 4 | Pins watched for a change of state |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wr_data_i | input | NEV+2 | Write data |
| rd_data_o | output | NEV+2 | Read data of the addressed register |
| boundary_i | input | 1 | Core is between instructions |
| irq_req_o | output | 1 | Interrupt request to the core |
| vec_o | output | 16 | Vector address for the current request |
| ack_i | input | 1 | Core has taken the request |
| ret_i | input | 1 | Core has left the current routine |
| level_o | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
The hardest state to reach is a high routine nested over a low routine, followed by two returns. Each return must uncover a request from a flag that software left set. The bench builds this state through the ports. It sets a low flag and acknowledges the 0x0018 request. While the low routine runs, it raises a high flag and acknowledges the preempting 0x0008 request. It then unwinds with return pulses and checks after each one which vector reappears. Clearing a flag in the same cycle as its event pulse is also driven on purpose, so that the set-over-clear ordering can be seen.

// File: rtl/irq_ctrl2.sv
module irq_ctrl2 #(
  parameter int NEV = 6,
  parameter logic [NEV+1:0] PERIPH_MASK = 'hF0,
  parameter logic [15:0] VEC_HI = 16'h0008,
  parameter logic [15:0] VEC_LO = 16'h0018
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] evt_i,
  input  logic           ext_pin_i,
  input  logic [3:0]     pc_pins_i,
  input  logic           wr_en_i,
  input  logic [1:0]     addr_i,
  input  logic [NEV+1:0] wr_data_i,
  output logic [NEV+1:0] rd_data_o,
  input  logic           boundary_i,
  output logic           irq_req_o,
  output logic [15:0]    vec_o,
  input  logic           ack_i,
  input  logic           ret_i,
  output logic [1:0]     level_o
);
  localparam int N = NEV + 2;

  logic [N-1:0] flag_q, en_q, pri_q;
  logic [3:0]   ctl_q;
  logic         ext_q;
  logic [3:0]   pc_q;
  logic         act_hi_q, act_lo_q;

  wire pmode     = ctl_q[0];
  wire gen_a     = ctl_q[1];
  wire gen_b     = ctl_q[2];
  wire edge_rise = ctl_q[3];

  wire ext_edge = edge_rise ? (ext_pin_i & ~ext_q) : (~ext_pin_i & ext_q);
  wire pc_chg   = |(pc_pins_i ^ pc_q);
  wire [N-1:0] set_v = {evt_i, pc_chg, ext_edge};

  wire [N-1:0] pend = flag_q & en_q;
  wire legacy_ok = gen_a & |(pend & (~PERIPH_MASK | {N{gen_b}}));
  wire hi_ok     = gen_a & |(pend & pri_q);
  wire lo_ok     = gen_b & |(pend & ~pri_q);
  wire idle      = ~act_hi_q & ~act_lo_q;

  wire take_hi = pmode ? (hi_ok & ~act_hi_q) : (legacy_ok & idle);
  wire take_lo = pmode & lo_ok & idle & ~take_hi;

  assign irq_req_o = boundary_i & (take_hi | take_lo);
  assign vec_o     = take_lo ? VEC_LO : VEC_HI;
  assign level_o   = {act_hi_q, act_lo_q};

  always_comb begin
    case (addr_i)
      2'd0:    rd_data_o = flag_q;
      2'd1:    rd_data_o = en_q;
      2'd2:    rd_data_o = pri_q;
      default: rd_data_o = {{(N-4){1'b0}}, ctl_q};
    endcase
  end

  wire wr_flag = wr_en_i & (addr_i == 2'd0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
      pri_q  <= '0;
      ctl_q  <= '0;
      ext_q  <= 1'b0;
      pc_q   <= '0;
    end else begin
      ext_q  <= ext_pin_i;
      pc_q   <= pc_pins_i;
      flag_q <= (wr_flag ? wr_data_i : flag_q) | set_v;
      if (wr_en_i && addr_i == 2'd1) en_q  <= wr_data_i;
      if (wr_en_i && addr_i == 2'd2) pri_q <= wr_data_i;
      if (wr_en_i && addr_i == 2'd3) ctl_q <= wr_data_i[3:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      act_hi_q <= 1'b0;
      act_lo_q <= 1'b0;
    end else if (ack_i && irq_req_o) begin
      if (take_hi) act_hi_q <= 1'b1;
      else         act_lo_q <= 1'b1;
    end else if (ret_i) begin
      if (act_hi_q) act_hi_q <= 1'b0;
      else          act_lo_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl2_chk.sv
module irq_ctrl2_chk #(
  parameter int NEV = 6,
  parameter logic [15:0] VEC_HI = 16'h0008,
  parameter logic [15:0] VEC_LO = 16'h0018
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NEV-1:0] evt_i,
  input logic           wr_en_i,
  input logic [1:0]     addr_i,
  input logic           boundary_i,
  input logic           irq_req_o,
  input logic [15:0]    vec_o,
  input logic           ack_i,
  input logic           ret_i,
  input logic [1:0]     level_o,
  input logic [NEV+1:0] flag_q
);
  assert_req_at_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> boundary_i);

  assert_vec_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (vec_o == VEC_HI || vec_o == VEC_LO));

  assert_high_blocks_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o[1] |-> !irq_req_o);

  assert_low_only_preempted_by_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o[0] && irq_req_o) |-> vec_o == VEC_HI);

  assert_ack_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && ack_i && vec_o == VEC_HI) |=> level_o[1]);

  assert_ack_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && ack_i && vec_o == VEC_LO) |=> level_o[0]);

  assert_return_inner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !ack_i && level_o == 2'b11) |=> level_o == 2'b01);

  assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd0) |=> (flag_q & $past(flag_q)) == $past(flag_q));

  assert_event_sets_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> (flag_q[NEV+1:2] & $past(evt_i)) == $past(evt_i));
endmodule

bind irq_ctrl2 irq_ctrl2_chk #(.NEV(NEV), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .boundary_i(boundary_i), .irq_req_o(irq_req_o), .vec_o(vec_o), .ack_i(ack_i),
  .ret_i(ret_i), .level_o(level_o), .flag_q(flag_q)
);

// File: tb/irq_ctrl2_tb.sv
module irq_ctrl2_tb;
  localparam int NEV = 6;
  localparam int N = NEV + 2;

  logic clk = 0, rst_n = 0;
  logic [NEV-1:0] evt = '0;
  logic ext = 0;
  logic [3:0] pc = '0;
  logic wr_en = 0;
  logic [1:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata;
  logic bnd = 1, req, ack = 0, ret = 0;
  logic [15:0] vec;
  logic [1:0] lvl;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_ctrl2 #(.NEV(NEV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ext_pin_i(ext), .pc_pins_i(pc),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .boundary_i(bnd), .irq_req_o(req), .vec_o(vec), .ack_i(ack), .ret_i(ret),
    .level_o(lvl)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; evt = '0; ext = 0; pc = '0; wr_en = 0; ack = 0; ret = 0; bnd = 1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_evt(input int k);
    @(negedge clk);
    evt[k] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic pulse_ret();
    @(negedge clk);
    ret = 1;
    @(negedge clk);
    ret = 0;
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 register reset", d, 0);
    end
    check("R1 req reset", req, 0);
    check("R1 level reset", lvl, 0);
  endtask

  task automatic t_event();
    logic [N-1:0] d;
    do_reset();
    pulse_evt(0);
    rd(0, d);
    check("R2 event sets flag", d, 8'h04);
    repeat (5) @(negedge clk);
    rd(0, d);
    check("R11 flag stays set", d, 8'h04);
    wr(0, 0);
    rd(0, d);
    check("R2 software clear", d, 0);
    @(negedge clk);
    wr_en = 1; addr = 0; wdata = 0; evt[3] = 1;
    @(negedge clk);
    wr_en = 0; evt = '0;
    rd(0, d);
    check("R2 set wins over clear", d, 8'h20);
  endtask

  task automatic t_ext();
    logic [N-1:0] d;
    do_reset();
    wr(3, 8'h08);
    @(negedge clk); ext = 1;
    @(negedge clk);
    rd(0, d);
    check("R3 rising edge sets", d, 8'h01);
    wr(0, 0);
    @(negedge clk); ext = 0;
    @(negedge clk);
    rd(0, d);
    check("R3 falling ignored when rising selected", d, 0);
    wr(3, 8'h00);
    @(negedge clk); ext = 1;
    @(negedge clk);
    rd(0, d);
    check("R3 rising ignored when falling selected", d, 0);
    @(negedge clk); ext = 0;
    @(negedge clk);
    rd(0, d);
    check("R3 falling edge sets", d, 8'h01);
  endtask

  task automatic t_pc();
    logic [N-1:0] d;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pc[i] = ~pc[i];
      @(negedge clk);
      rd(0, d);
      check("R4 pin change sets flag", d, 8'h02);
      wr(0, 0);
      rd(0, d);
      check("R4 flag cleared", d, 0);
    end
  endtask

  task automatic t_gate();
    do_reset();
    wr(3, 8'h02);
    pulse_evt(0);
    @(negedge clk);
    check("R5 no request while disabled", req, 0);
    wr(1, 8'h04);
    @(negedge clk);
    check("R5 request when enabled", req, 1);
    check("R6 legacy vector", vec, 16'h0008);
    bnd = 0;
    #1 check("R5 no request off boundary", req, 0);
    bnd = 1;
  endtask

  task automatic t_legacy();
    do_reset();
    wr(1, 8'h14);
    wr(2, 8'h00);
    pulse_evt(2);
    wr(3, 8'h02);
    @(negedge clk);
    check("R6 peripheral gated by bit 2", req, 0);
    wr(3, 8'h06);
    @(negedge clk);
    check("R6 peripheral passes", req, 1);
    check("R6 vector 0x0008 with low priority bit", vec, 16'h0008);
    wr(0, 8'h04);
    wr(3, 8'h04);
    @(negedge clk);
    check("R6 global bit 1 gates all", req, 0);
  endtask

  task automatic t_prio();
    do_reset();
    wr(1, 8'h0C);
    wr(2, 8'h04);
    pulse_evt(1);
    wr(3, 8'h03);
    @(negedge clk);
    check("R7 low blocked by bit 2", req, 0);
    wr(3, 8'h05);
    @(negedge clk);
    check("R7 low request", req, 1);
    check("R7 low vector", vec, 16'h0018);
    wr(0, 8'h04);
    @(negedge clk);
    check("R7 high blocked by bit 1", req, 0);
    wr(0, 8'h0C);
    wr(3, 8'h07);
    @(negedge clk);
    check("R7 both pending request", req, 1);
    check("R7 high wins", vec, 16'h0008);
  endtask

  task automatic t_nest();
    do_reset();
    wr(1, 8'h0C);
    wr(2, 8'h04);
    wr(3, 8'h07);
    pulse_evt(1);
    @(negedge clk);
    check("R7 low vector before ack", vec, 16'h0018);
    pulse_ack();
    check("R8 low level recorded", lvl, 2'b01);
    check("R9 low pending blocked in low routine", req, 0);
    pulse_evt(0);
    @(negedge clk);
    check("R9 high preempts low", req, 1);
    check("R9 preempt vector", vec, 16'h0008);
    pulse_ack();
    check("R8 nested level", lvl, 2'b11);
    check("R9 nothing in high routine", req, 0);
    pulse_ret();
    check("R10 return ends high", lvl, 2'b01);
    check("R11 high flag requests again", req, 1);
    wr(0, 8'h08);
    @(negedge clk);
    check("R9 low still blocked", req, 0);
    pulse_ret();
    check("R10 return ends low", lvl, 2'b00);
    check("R11 low flag requests again", req, 1);
    check("R11 low vector again", vec, 16'h0018);
  endtask

  task automatic t_legacy_ack();
    do_reset();
    wr(1, 8'h04);
    wr(3, 8'h02);
    pulse_evt(0);
    pulse_ack();
    check("R8 legacy ack records high", lvl, 2'b10);
    check("R8 no request in legacy routine", req, 0);
    pulse_ret();
    check("R10 legacy return", lvl, 2'b00);
    check("R11 legacy flag requests again", req, 1);
  endtask

  initial begin
    t_reset();
    t_event();
    t_ext();
    t_pc();
    t_gate();
    t_legacy();
    t_prio();
    t_nest();
    t_legacy_ack();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule